// File: doc/BRIEF.md
# Host Bus Master with Address-Latch Strobes

This block drives a parallel external bus on behalf of on-chip logic. An internal requester places an address, write data, byte enables and a direction bit on a request port and holds them with a valid flag until the block answers with a one-cycle acknowledge, which carries read data or an error flag. The block then runs an external bus cycle. Each cycle has an address phase and then a data phase, and each phase lasts a fixed number of clock cycles set by a parameter.

The external side works in one of two layouts. In the shared layout, the data pins carry the address during the address phase and the data during the data phase. In the split layout, the address travels only on dedicated address pins, which give a 20-bit (1 MB) space. The data path is 8 or 16 bits wide. A two-bit strobe field and an extension bit set the roles of the strobe pins: an address-latch pulse alone, a single chip select alone, or the latch pulse together with two or four chip selects. The two or four selects are decoded from the top address bits. In 16-bit mode, active-low byte-select outputs are driven only when they are enabled. A partial-width access made while they are disabled is refused with an error.

The configuration inputs are sampled when a request is accepted and stay fixed for that access.

Top module: `hbus_master`

## Requirements
- R1: During and after reset, with no request pending, the block holds these values: `bus_ale` = 0, `bus_csn` = 4'hF, `bus_rd_n` = `bus_wr_n` = 1, `bus_ad_oe` = 0, `bus_addr` = 0, `bus_bsel_n` = 2'b11, `req_ack` = 0, `req_err` = 0 and `req_rdata` = 0.
- R2: A request is taken at a clock edge where the block is idle and `req_valid` is 1. The next ADDR_CYC cycles form the address phase, the following DATA_CYC cycles form the data phase, and the cycle after that has `req_ack` = 1 for exactly one cycle. A request that is still held, or newly presented, in the acknowledge cycle is taken at the earliest one idle cycle later.
- R3: In the shared layout (`cfg_mux` = 1), `bus_ad_oe` is 1 throughout the address phase and `bus_ad_out` carries the request address. In 8-bit mode (`cfg_wide` = 0) only bits 7:0 carry the address and bits 15:8 are 0. In the split layout, the data pins are not driven during the address phase.
- R4: `bus_ale` is 1 in every address-phase cycle and 0 at all other times, whenever the strobe setting includes a latch pulse: strobe field 0, 2 or 3 with the extension bit clear, or any field with the extension bit set. With field 1 and the extension bit clear, `bus_ale` stays 0.
- R5: With strobe field 1 and the extension bit clear, `bus_csn[0]` is 0 throughout both phases and `bus_csn[3:1]` stay 1.
- R6: With strobe field 3 and the extension bit clear, `bus_csn[a]` is 0 throughout both phases, where `a` is address bit 19. `bus_csn[3:2]` and the other low select stay 1.
- R7: With strobe field 0 and the extension bit set, `bus_csn[n]` is 0 throughout both phases, where `n` is address bits 19:18, and the other three selects stay 1. Any setting not named in R5 to R7 leaves all selects at 1.
- R8: `bus_rd_n` is 0 only during the data phase of a read, and `bus_wr_n` is 0 only during the data phase of a write. In a write data phase, `bus_ad_oe` = 1 and `bus_ad_out` carries the write data with disabled byte lanes driven as 0. In a read data phase, `bus_ad_oe` = 0.
- R9: In the acknowledge cycle of a read, `req_rdata` equals `bus_ad_in` as sampled in the last data-phase cycle, with disabled byte lanes returned as 0. Lane 0 is bits 7:0 and lane 1 is bits 15:8. In 8-bit mode only lane 0 is enabled. In 16-bit mode both lanes are enabled, unless byte selects are on, in which case `req_be` chooses the lanes.
- R10: `bus_addr` carries the full request address throughout both phases in either layout, and is 0 otherwise.
- R11: In 16-bit mode with `cfg_bsel_en` = 1, `bus_bsel_n` equals the inverted `req_be` throughout both phases. In every other case it stays 2'b11.
- R12: In 16-bit mode, a request with `req_be` = 2'b00, or with `req_be` other than 2'b11 while `cfg_bsel_en` = 0, starts no bus cycle. It is answered one cycle after acceptance with `req_ack` = 1 and `req_err` = 1. Accepted accesses end with `req_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Request address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = lane 7:0 |
| req_ack | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Refused request, valid with `req_ack` |
| req_rdata | output | 16 | Read data, valid with `req_ack` |
| cfg_mux | input | 1 | 1 = shared address/data pins |
| cfg_wide | input | 1 | 1 = 16-bit data, 0 = 8-bit |
| cfg_bsel_en | input | 1 | Enable byte-select outputs in 16-bit mode |
| cfg_strobe | input | 2 | Strobe role field |
| cfg_strobe_ext | input | 1 | Strobe role extension bit |
| bus_ad_out | output | 16 | Data (and shared address) pins, outgoing value |
| bus_ad_oe | output | 1 | Drive enable for the data pins |
| bus_ad_in | input | 16 | Data pins, incoming value |
| bus_addr | output | 20 | Dedicated address pins |
| bus_ale | output | 1 | Address-latch pulse, active high |
| bus_csn | output | 4 | Chip selects, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_bsel_n | output | 2 | Byte selects, active low |

## Verification
Two events can occur in the same cycle: the acknowledge of one access and the arrival of the next request. The bench provokes this by replacing the request in the acknowledge cycle of a write with a read to a different address, keeping `req_valid` high. The run passes only if that cycle shows a single acknowledge and the following cycle is idle, with no strobe, select or pin drive. The read's address phase must then begin exactly one cycle later, with its own address and direction, and the earlier write must not be replayed.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    localparam int HB_DW   = 16;
    localparam int HB_BW   = HB_DW / 8;
    localparam int HB_AW   = 20;
    localparam int HB_NCS  = 4;
    localparam int HB_CSW  = $clog2(HB_NCS);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA,
        PH_DONE
    } hb_phase_e;

    typedef enum logic [1:0] {
        STB_LE,
        STB_CS1,
        STB_LE_CS2,
        STB_LE_CS4
    } hb_strobe_e;

    typedef struct packed {
        logic       mux;
        logic       wide;
        logic       bsel_en;
        hb_strobe_e strobe;
    } hb_cfg_t;

    typedef struct packed {
        logic              we;
        logic [HB_AW-1:0]  addr;
        logic [HB_DW-1:0]  wdata;
        logic [HB_BW-1:0]  be;
    } hb_req_t;

    // Field plus extension bit -> pin role; unlisted codes fall back to latch only
    function automatic hb_strobe_e strobe_decode(input logic [1:0] field, input logic ext);
        hb_strobe_e r;
        if (!ext) begin
            case (field)
                2'd1:    r = STB_CS1;
                2'd3:    r = STB_LE_CS2;
                default: r = STB_LE;
            endcase
        end else begin
            r = (field == 2'd0) ? STB_LE_CS4 : STB_LE;
        end
        return r;
    endfunction

    function automatic logic req_legal(input hb_cfg_t c, input logic [HB_BW-1:0] be);
        if (!c.wide) return 1'b1;
        if (be == '0) return 1'b0;
        return c.bsel_en || (be == '1);
    endfunction

    // Byte lanes that carry data for this access
    function automatic logic [HB_BW-1:0] lane_mask(input hb_cfg_t c, input logic [HB_BW-1:0] be);
        if (!c.wide)   return HB_BW'(1);
        if (c.bsel_en) return be;
        return '1;
    endfunction

    function automatic logic [HB_DW-1:0] lane_bits(input logic [HB_BW-1:0] m);
        logic [HB_DW-1:0] b;
        for (int i = 0; i < HB_BW; i++) begin
            b[i*8 +: 8] = {8{m[i]}};
        end
        return b;
    endfunction

endpackage

// File: rtl/hbus_seq.sv
module hbus_seq
    import hbus_pkg::*;
#(
    parameter int ADDR_CYC = 2,
    parameter int DATA_CYC = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  logic      req_ok,
    output hb_phase_e phase,
    output logic      accept,
    output logic      capture,
    output logic      ack,
    output logic      err
);

    localparam int MAXC = (ADDR_CYC > DATA_CYC) ? ADDR_CYC : DATA_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] A_LAST = CW'(ADDR_CYC - 1);
    localparam logic [CW-1:0] D_LAST = CW'(DATA_CYC - 1);

    hb_phase_e     ph_q;
    logic [CW-1:0] cnt_q;
    logic          err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (req_valid) begin
                        err_q <= !req_ok;
                        ph_q  <= req_ok ? PH_ADDR : PH_DONE;
                    end
                end
                PH_ADDR: begin
                    if (cnt_q == A_LAST) begin
                        cnt_q <= '0;
                        ph_q  <= PH_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (cnt_q == D_LAST) begin
                        cnt_q <= '0;
                        ph_q  <= PH_DONE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_DONE: ph_q <= PH_IDLE;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign phase   = ph_q;
    assign accept  = (ph_q == PH_IDLE) && req_valid;
    assign capture = (ph_q == PH_DATA) && (cnt_q == D_LAST);
    assign ack     = (ph_q == PH_DONE);
    assign err     = ack && err_q;

    // R2: completion pulse lasts one cycle
    a_r2_ack_single: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R2: data phase is entered only from the address phase
    a_r2_data_after_addr: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && $past(phase) != PH_DATA) |-> $past(phase) == PH_ADDR);

    // R12: a refused request is answered on the next cycle with the error flag
    a_r12_reject_next: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_ok) |=> (ack && err));

endmodule

// File: rtl/hbus_strobe_map.sv
module hbus_strobe_map
    import hbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  hb_phase_e         phase,
    input  hb_strobe_e        strobe,
    input  logic [HB_CSW-1:0] sel,
    output logic              ale,
    output logic [HB_NCS-1:0] csn
);

    logic              active;
    logic              cs_en;
    logic [HB_CSW-1:0] cs_idx;

    always_comb begin
        active = (phase == PH_ADDR) || (phase == PH_DATA);
        cs_en  = 1'b0;
        cs_idx = '0;
        unique case (strobe)
            STB_CS1: cs_en = 1'b1;
            STB_LE_CS2: begin
                cs_en     = 1'b1;
                cs_idx[0] = sel[HB_CSW-1];
            end
            STB_LE_CS4: begin
                cs_en  = 1'b1;
                cs_idx = sel;
            end
            default: cs_en = 1'b0;
        endcase
        ale = (strobe != STB_CS1) && (phase == PH_ADDR);
        for (int i = 0; i < HB_NCS; i++) begin
            csn[i] = !(active && cs_en && (cs_idx == HB_CSW'(i)));
        end
    end

    // R6/R7: never more than one device selected
    a_r7_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~csn));

    // R5: a select never moves from one device to another without going idle
    a_r5_no_select_hop: assert property (@(posedge clk) disable iff (rst)
        !$stable(csn) |-> (csn == '1 || $past(csn) == '1));

endmodule

// File: rtl/hbus_pins.sv
module hbus_pins
    import hbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  hb_phase_e        phase,
    input  logic             capture,
    input  hb_req_t          req,
    input  hb_cfg_t          cfg,
    input  logic [HB_DW-1:0] ad_in,
    output logic [HB_DW-1:0] ad_out,
    output logic             ad_oe,
    output logic [HB_AW-1:0] addr_out,
    output logic             rd_n,
    output logic             wr_n,
    output logic [HB_BW-1:0] bsel_n,
    output logic [HB_DW-1:0] rdata
);

    logic             in_addr;
    logic             in_data;
    logic             active;
    logic [HB_BW-1:0] data_mask;
    logic [HB_BW-1:0] addr_mask;

    always_comb begin
        in_addr   = (phase == PH_ADDR);
        in_data   = (phase == PH_DATA);
        active    = in_addr || in_data;
        data_mask = lane_mask(cfg, req.be);
        addr_mask = cfg.wide ? '1 : HB_BW'(1);

        ad_oe  = (in_addr && cfg.mux) || (in_data && req.we);
        ad_out = '0;
        if (in_addr && cfg.mux) begin
            ad_out = req.addr[HB_DW-1:0] & lane_bits(addr_mask);
        end else if (in_data && req.we) begin
            ad_out = req.wdata & lane_bits(data_mask);
        end

        addr_out = active ? req.addr : '0;
        rd_n     = !(in_data && !req.we);
        wr_n     = !(in_data && req.we);
        bsel_n   = (active && cfg.wide && cfg.bsel_en) ? ~req.be : '1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (capture && !req.we) begin
            rdata <= ad_in & lane_bits(data_mask);
        end
    end

    // R8: the pins are never driven while the device is asked to drive them
    a_r8_no_contention: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    // R8: read and write strobes are never low together
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

endmodule

// File: rtl/hbus_master.sv
module hbus_master
    import hbus_pkg::*;
#(
    parameter int ADDR_CYC = 2,
    parameter int DATA_CYC = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_we,
    input  logic [HB_AW-1:0]    req_addr,
    input  logic [HB_DW-1:0]    req_wdata,
    input  logic [HB_BW-1:0]    req_be,
    output logic                req_ack,
    output logic                req_err,
    output logic [HB_DW-1:0]    req_rdata,
    input  logic                cfg_mux,
    input  logic                cfg_wide,
    input  logic                cfg_bsel_en,
    input  logic [1:0]          cfg_strobe,
    input  logic                cfg_strobe_ext,
    output logic [HB_DW-1:0]    bus_ad_out,
    output logic                bus_ad_oe,
    input  logic [HB_DW-1:0]    bus_ad_in,
    output logic [HB_AW-1:0]    bus_addr,
    output logic                bus_ale,
    output logic [HB_NCS-1:0]   bus_csn,
    output logic                bus_rd_n,
    output logic                bus_wr_n,
    output logic [HB_BW-1:0]    bus_bsel_n
);

    hb_cfg_t   cfg_live;
    hb_cfg_t   cfg_q;
    hb_req_t   req_q;
    hb_phase_e phase;
    logic      accept;
    logic      capture;
    logic      ok_now;

    always_comb begin
        cfg_live.mux     = cfg_mux;
        cfg_live.wide    = cfg_wide;
        cfg_live.bsel_en = cfg_bsel_en;
        cfg_live.strobe  = strobe_decode(cfg_strobe, cfg_strobe_ext);
        ok_now           = req_legal(cfg_live, req_be);
    end

    // Request and configuration are frozen for the whole access
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            cfg_q <= '0;
        end else if (accept) begin
            req_q <= '{we: req_we, addr: req_addr, wdata: req_wdata, be: req_be};
            cfg_q <= cfg_live;
        end
    end

    hbus_seq #(
        .ADDR_CYC (ADDR_CYC),
        .DATA_CYC (DATA_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ok    (ok_now),
        .phase     (phase),
        .accept    (accept),
        .capture   (capture),
        .ack       (req_ack),
        .err       (req_err)
    );

    hbus_strobe_map u_strobe (
        .clk    (clk),
        .rst    (rst),
        .phase  (phase),
        .strobe (cfg_q.strobe),
        .sel    (req_q.addr[HB_AW-1 -: HB_CSW]),
        .ale    (bus_ale),
        .csn    (bus_csn)
    );

    hbus_pins u_pins (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .capture  (capture),
        .req      (req_q),
        .cfg      (cfg_q),
        .ad_in    (bus_ad_in),
        .ad_out   (bus_ad_out),
        .ad_oe    (bus_ad_oe),
        .addr_out (bus_addr),
        .rd_n     (bus_rd_n),
        .wr_n     (bus_wr_n),
        .bsel_n   (bus_bsel_n),
        .rdata    (req_rdata)
    );

    // R4: the latch pulse never overlaps a data strobe or the acknowledge
    a_r4_ale_clear: assert property (@(posedge clk) disable iff (rst)
        bus_ale |-> (bus_rd_n && bus_wr_n && !req_ack));

    // R12: a refused access shows no select or strobe in its answer cycle
    a_r12_quiet_reject: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (bus_csn == '1 && bus_rd_n && bus_wr_n && !bus_ad_oe));

endmodule

// File: tb/hbus_master_bench.sv
module hbus_master_bench;
    import hbus_pkg::*;

    localparam int AC = 2;
    localparam int DC = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_we;
    logic [19:0] req_addr;
    logic [15:0] req_wdata;
    logic [1:0]  req_be;
    logic        req_ack, req_err;
    logic [15:0] req_rdata;
    logic        c_mux, c_wide, c_bsel, c_ext;
    logic [1:0]  c_field;
    logic [15:0] bus_ad_out, bus_ad_in;
    logic        bus_ad_oe;
    logic [19:0] bus_addr;
    logic        bus_ale, bus_rd_n, bus_wr_n;
    logic [3:0]  bus_csn;
    logic [1:0]  bus_bsel_n;
    logic [15:0] rd_pat;

    logic        cur_we;
    logic [19:0] cur_a;
    logic [15:0] cur_wd;
    logic [1:0]  cur_be;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    // Device model: drives its pattern only while the read strobe is low
    assign bus_ad_in = bus_rd_n ? 16'hFFFF : rd_pat;

    hbus_master #(.ADDR_CYC(AC), .DATA_CYC(DC)) u_hbus_master (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .req_ack(req_ack), .req_err(req_err), .req_rdata(req_rdata),
        .cfg_mux(c_mux), .cfg_wide(c_wide), .cfg_bsel_en(c_bsel),
        .cfg_strobe(c_field), .cfg_strobe_ext(c_ext),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
        .bus_addr(bus_addr), .bus_ale(bus_ale), .bus_csn(bus_csn),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_bsel_n(bus_bsel_n)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic legal();
        if (!c_wide) return 1'b1;
        return (cur_be != 2'b00) && (c_bsel || cur_be == 2'b11);
    endfunction

    function automatic logic [15:0] lane_b();
        logic [1:0] m;
        m = !c_wide ? 2'b01 : (c_bsel ? cur_be : 2'b11);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    function automatic logic [31:0] pins_now();
        return {bus_ale, bus_csn, bus_rd_n, bus_wr_n, bus_ad_oe, bus_addr,
                bus_bsel_n, req_ack, req_err};
    endfunction

    // ph: 0 idle, 1 address, 2 data, 3 acknowledge
    function automatic logic [31:0] exp_pins(input int ph);
        logic       le, en, act, pa, pd, pk;
        logic [1:0] idx;
        logic [3:0] cs;
        le = !(c_field == 2'd1 && !c_ext);
        en = 1'b1;
        idx = 2'd0;
        if (!c_ext && c_field == 2'd1)      idx = 2'd0;
        else if (!c_ext && c_field == 2'd3) idx = {1'b0, cur_a[19]};
        else if (c_ext && c_field == 2'd0)  idx = cur_a[19:18];
        else                                en = 1'b0;
        pa  = (ph == 1);
        pd  = (ph == 2);
        pk  = (ph == 3);
        act = pa || pd;
        cs  = (act && en) ? ~(4'b0001 << idx) : 4'hF;
        return {le && pa, cs, !(pd && !cur_we), !(pd && cur_we),
                (pa && c_mux) || (pd && cur_we), act ? cur_a : 20'h0,
                (act && c_wide && c_bsel) ? ~cur_be : 2'b11, pk, pk && !legal()};
    endfunction

    task automatic xfer(input string tag, input bit chained, input logic we,
                        input logic [19:0] a, input logic [15:0] wd,
                        input logic [1:0] be, input bit keep);
        int n;
        int ph;
        cur_we = we; cur_a = a; cur_wd = wd; cur_be = be;
        req_we = we; req_addr = a; req_wdata = wd; req_be = be; req_valid = 1'b1;
        if (chained) begin
            @(negedge clk);
            chk({tag, " R2 gap after ack"}, {32'h0, pins_now()}, {32'h0, exp_pins(0)});
        end
        n = legal() ? AC + DC + 1 : 1;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (!legal())     ph = 3;
            else if (k <= AC) ph = 1;
            else if (k <= AC + DC) ph = 2;
            else              ph = 3;
            chk(tag, {32'h0, pins_now()}, {32'h0, exp_pins(ph)});
            if (ph == 1 && c_mux)
                chk({tag, " R3 address on data pins"}, {48'h0, bus_ad_out},
                    {48'h0, a[15:0] & (c_wide ? 16'hFFFF : 16'h00FF)});
            if (ph == 2 && we)
                chk({tag, " R8 write data"}, {48'h0, bus_ad_out}, {48'h0, wd & lane_b()});
            if (ph == 3 && !we && legal())
                chk({tag, " R9 read data"}, {48'h0, req_rdata}, {48'h0, rd_pat & lane_b()});
        end
        if (!keep) begin
            req_valid = 1'b0;
            @(negedge clk);
            chk({tag, " R1 idle after access"}, {32'h0, pins_now()}, {32'h0, exp_pins(0)});
        end
    endtask

    task automatic set_cfg(input logic mux, input logic wide, input logic bsel,
                           input logic [1:0] field, input logic ext);
        c_mux = mux; c_wide = wide; c_bsel = bsel; c_field = field; c_ext = ext;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
        cur_we = 1'b0; cur_a = '0; cur_wd = '0; cur_be = '0; rd_pat = 16'h0;
        set_cfg(1'b1, 1'b1, 1'b0, 2'd0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R1 pins in reset", {32'h0, pins_now()}, {32'h0, exp_pins(0)});
        chk("R1 rdata in reset", {48'h0, req_rdata}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pins after reset", {32'h0, pins_now()}, {32'h0, exp_pins(0)});
    endtask

    task automatic t_mux_latch();
        set_cfg(1'b1, 1'b1, 1'b0, 2'd0, 1'b0);
        rd_pat = 16'h3C5A;
        xfer("R3 R4 shared write", 0, 1'b1, 20'h4_1234, 16'hBEEF, 2'b11, 0);
        xfer("R2 R9 shared read",  0, 1'b0, 20'h8_00F0, 16'h0000, 2'b11, 0);
    endtask

    task automatic t_split_cs();
        set_cfg(1'b0, 1'b1, 1'b0, 2'd1, 1'b0);
        rd_pat = 16'h9001;
        xfer("R5 R10 split read",  0, 1'b0, 20'hF_ABCD, 16'h0, 2'b11, 0);
        xfer("R5 R10 split write", 0, 1'b1, 20'h0_0011, 16'h1357, 2'b11, 0);
    endtask

    task automatic t_two_sel();
        set_cfg(1'b1, 1'b1, 1'b0, 2'd3, 1'b0);
        rd_pat = 16'h7777;
        xfer("R6 low half",  0, 1'b1, 20'h7_FFFF, 16'h2468, 2'b11, 0);
        xfer("R6 high half", 0, 1'b0, 20'h8_0000, 16'h0,    2'b11, 0);
    endtask

    task automatic t_four_sel();
        set_cfg(1'b0, 1'b1, 1'b0, 2'd0, 1'b1);
        rd_pat = 16'h1E2D;
        for (int q = 0; q < 4; q++) begin
            xfer("R7 quarter", 0, q[0], {q[1:0], 18'h0_0ABC}, 16'hC0DE, 2'b11, 0);
        end
    endtask

    task automatic t_narrow();
        set_cfg(1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
        rd_pat = 16'hA5C3;
        xfer("R9 narrow read",  0, 1'b0, 20'h0_12FE, 16'h0,    2'b00, 0);
        xfer("R3 narrow write", 0, 1'b1, 20'h0_3456, 16'hFF81, 2'b10, 0);
    endtask

    task automatic t_byte_sel();
        set_cfg(1'b0, 1'b1, 1'b1, 2'd1, 1'b0);
        rd_pat = 16'h6B4F;
        xfer("R11 low byte write", 0, 1'b1, 20'h0_0100, 16'hAA55, 2'b01, 0);
        xfer("R11 high byte read", 0, 1'b0, 20'h0_0101, 16'h0,    2'b10, 0);
    endtask

    task automatic t_reject();
        set_cfg(1'b0, 1'b1, 1'b0, 2'd1, 1'b0);
        xfer("R12 partial without byte selects", 0, 1'b1, 20'h0_0200, 16'h1111, 2'b01, 0);
        set_cfg(1'b0, 1'b1, 1'b1, 2'd1, 1'b0);
        xfer("R12 empty byte enables", 0, 1'b0, 20'h0_0202, 16'h0, 2'b00, 0);
        rd_pat = 16'h0F0F;
        xfer("R12 legal access afterwards", 0, 1'b0, 20'h0_0204, 16'h0, 2'b11, 0);
    endtask

    task automatic t_fallback();
        set_cfg(1'b1, 1'b1, 1'b0, 2'd2, 1'b0);
        xfer("R4 field 2 latch only", 0, 1'b1, 20'hC_0001, 16'h5A5A, 2'b11, 0);
        set_cfg(1'b1, 1'b1, 1'b0, 2'd1, 1'b1);
        xfer("R7 field 1 ext set latch only", 0, 1'b1, 20'h4_0002, 16'hA5A5, 2'b11, 0);
    endtask

    task automatic t_back_to_back();
        set_cfg(1'b1, 1'b1, 1'b0, 2'd0, 1'b1);
        rd_pat = 16'hD00D;
        xfer("R2 first write",  0, 1'b1, 20'h4_0AAA, 16'h0F1E, 2'b11, 1);
        xfer("R2 chained read", 1, 1'b0, 20'hC_0555, 16'h0,    2'b11, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        t_reset();
        t_mux_latch();
        t_split_cs();
        t_two_sel();
        t_four_sel();
        t_narrow();
        t_byte_sel();
        t_reject();
        t_fallback();
        t_back_to_back();
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual no completion expected completion");
        summary();
        $finish;
    end

endmodule